// File: doc/BRIEF.md
# Addressable Latch with Clearing Demultiplexer

This block holds a row of single-bit storage cells, eight by default, and writes one data bit into the cell picked by a binary address. Two active-low controls, a write enable and a clear, choose one of four modes. In write mode the addressed cell takes the data bit and every other cell keeps its value. In hold mode every cell keeps its value. In demultiplex mode the addressed output takes the data bit and all other outputs go low. In clear mode every output goes low.

Each cell drives its own bit of the parallel output. Stepping the address while in write mode therefore loads a serial bit stream into a parallel word. The demultiplex mode turns the same array into a one-of-N active-high decoder.

Storage is a clocked register. The mode is decoded combinationally from the two controls, and every change appears on the outputs one clock edge after the inputs that cause it.

Top module: `addr_demux_latch`

## Requirements
- R1: In write mode (clr_n=1, wen_n=0), the cell whose index equals the address value takes din at the clock edge, so address k loads output bit k.
- R2: In write mode, every cell other than the addressed one keeps its value across the edge.
- R3: In hold mode (clr_n=1, wen_n=1), all cells keep their values whatever din and addr are.
- R4: In demultiplex mode (clr_n=0, wen_n=0), after the edge output bit addr equals din and every other output bit is 0.
- R5: In clear mode (clr_n=0, wen_n=1), all outputs are 0 after the edge whatever din and addr are.
- R6: After demultiplex mode ends, the cells hold exactly the word shown during that mode, with the unselected cells cleared.
- R7: Writing bits in turn to addresses 0 up to NCELL-1 in write mode leaves the whole serial stream visible on q at once.
- R8: Outputs change only at a rising clock edge and show the result of the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the cells update on its rising edge |
| din | input | 1 | Data bit steered to the addressed cell |
| addr | input | AW (3) | Cell index |
| wen_n | input | 1 | Write enable, active low |
| clr_n | input | 1 | Clear, active low; selects demultiplex or clear mode |
| q | output | NCELL (8) | Parallel contents of all cells |

## Verification
A single clear input does two jobs: it gates the full-row clear, and with the write enable low it turns the block into a decoder. Both of those land in the same cell update when the demultiplex mode writes a 1 to the addressed cell and clears every other cell in the same edge. The bench provokes this with a row already full of ones, then checks that exactly one bit survives and that a later hold keeps that one-hot word. It also moves from write mode straight into demultiplex mode, and from demultiplex straight into clear, on consecutive edges. A scoreboard model that applies the mode table independently judges every edge.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

   typedef enum logic [1:0] {
      AL_WRITE = 2'd0,
      AL_HOLD  = 2'd1,
      AL_DEMUX = 2'd2,
      AL_CLEAR = 2'd3
   } al_mode_e;

   // clr_n selects the clearing pair, wen_n selects write versus keep
   function automatic al_mode_e al_mode_of(input logic clr_n, input logic wen_n);
      al_mode_e m;
      case ({clr_n, wen_n})
         2'b10:   m = AL_WRITE;
         2'b11:   m = AL_HOLD;
         2'b00:   m = AL_DEMUX;
         default: m = AL_CLEAR;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/al_mode_dec.sv
module al_mode_dec
   import addr_latch_pkg::*;
(
   input  logic     clr_n,
   input  logic     wen_n,
   output al_mode_e mode,
   output logic     load_sel,
   output logic     zero_rest
);
   always_comb begin
      mode      = al_mode_of(clr_n, wen_n);
      load_sel  = (mode == AL_WRITE) || (mode == AL_DEMUX);
      zero_rest = (mode == AL_DEMUX) || (mode == AL_CLEAR);
   end
endmodule

// File: rtl/al_sel_dec.sv
module al_sel_dec #(
   parameter int NCELL      = 8,
   parameter int AW         = 3,
   parameter bit SHIFT_IMPL = 1'b0
) (
   input  logic [AW-1:0]    addr,
   output logic [NCELL-1:0] sel
);
   generate
      if (SHIFT_IMPL) begin : g_shift
         assign sel = NCELL'(1) << addr;
      end else begin : g_cmp
         for (genvar k = 0; k < NCELL; k++) begin : g_bit
            assign sel[k] = (addr == AW'(k));
         end
      end
   endgenerate
endmodule

// File: rtl/al_cell.sv
module al_cell (
   input  logic clk,
   input  logic sel,
   input  logic load_sel,
   input  logic zero_rest,
   input  logic din,
   output logic q
);
   logic q_nxt;

   always_comb begin
      q_nxt = q;
      if (sel && load_sel)
         q_nxt = din;
      else if (zero_rest)
         q_nxt = 1'b0;
   end

   always_ff @(posedge clk) q <= q_nxt;
endmodule

// File: rtl/addr_demux_latch.sv
module addr_demux_latch
   import addr_latch_pkg::*;
#(
   parameter int NCELL      = 8,
   parameter int AW         = $clog2(NCELL),
   parameter bit SHIFT_IMPL = 1'b0
) (
   input  logic             clk,
   input  logic             din,
   input  logic [AW-1:0]    addr,
   input  logic             wen_n,
   input  logic             clr_n,
   output logic [NCELL-1:0] q
);
   localparam int MIN_AW = $clog2(NCELL);

   generate
      if (NCELL < 2) begin : g_bad_ncell
         $error("NCELL must be at least 2");
      end
      if (AW < MIN_AW) begin : g_bad_aw
         $error("AW too narrow to address every cell");
      end
   endgenerate

   al_mode_e         mode;
   logic             load_sel;
   logic             zero_rest;
   logic [NCELL-1:0] sel;

   al_mode_dec u_mode (
      .clr_n     (clr_n),
      .wen_n     (wen_n),
      .mode      (mode),
      .load_sel  (load_sel),
      .zero_rest (zero_rest)
   );

   al_sel_dec #(.NCELL(NCELL), .AW(AW), .SHIFT_IMPL(SHIFT_IMPL)) u_sel (
      .addr (addr),
      .sel  (sel)
   );

   generate
      for (genvar i = 0; i < NCELL; i++) begin : g_cell
         al_cell u_cell (
            .clk       (clk),
            .sel       (sel[i]),
            .load_sel  (load_sel),
            .zero_rest (zero_rest),
            .din       (din),
            .q         (q[i])
         );
      end
   endgenerate

   logic unused_mode;
   assign unused_mode = ^mode;
endmodule

// File: rtl/addr_demux_latch_chk.sv
module addr_demux_latch_chk #(
   parameter int NCELL = 8,
   parameter int AW    = 3
) (
   input logic             clk,
   input logic             din,
   input logic [AW-1:0]    addr,
   input logic             wen_n,
   input logic             clr_n,
   input logic [NCELL-1:0] q
);
   logic             primed = 1'b0;
   logic [NCELL-1:0] mask;

   assign mask = NCELL'(1) << addr;

   // any clearing mode assigns every cell, so q is defined from then on
   always @(posedge clk) if (!clr_n) primed <= 1'b1;

   AST_WRITE_SEL: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && !wen_n) |=> ((|(q & $past(mask))) == $past(din))); // R1

   AST_WRITE_KEEP: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && !wen_n) |=> (((q ^ $past(q)) & ~$past(mask)) == '0)); // R2

   AST_HOLD_ALL: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && wen_n) |=> (q == $past(q))); // R3

   AST_DEMUX_WORD: assert property (@(posedge clk) disable iff (!primed)
      (!clr_n && !wen_n) |=> (q == ($past(din) ? $past(mask) : '0))); // R4

   AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (!primed)
      (!clr_n && !wen_n) |=> $onehot0(q)); // R6

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!primed)
      (!clr_n && wen_n) |=> (q == '0)); // R5
endmodule

bind addr_demux_latch addr_demux_latch_chk #(.NCELL(NCELL), .AW(AW)) u_chk (.*);

// File: tb/addr_demux_latch_tb.sv
module addr_demux_latch_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCELL      = 8;
   localparam int AW         = 3;

   typedef struct {
      logic [NCELL-1:0] q;
      string            tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             din = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic             wen_n = 1'b1;
   logic             clr_n = 1'b0;
   logic [NCELL-1:0] q;

   exp_t             sb[$];
   logic [NCELL-1:0] model = '0;
   int               n_chk = 0;
   int               n_fail = 0;
   bit               done = 1'b0;

   addr_demux_latch #(.NCELL(NCELL)) u_dut (
      .clk   (clk),
      .din   (din),
      .addr  (addr),
      .wen_n (wen_n),
      .clr_n (clr_n),
      .q     (q)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // driver: one input set per cycle, one expected word per cycle
   task automatic step(input logic d, input logic [AW-1:0] a,
                       input logic en_n, input logic rn, input string tag);
      exp_t e;
      @(negedge clk);
      din = d; addr = a; wen_n = en_n; clr_n = rn;
      case ({rn, en_n})
         2'b10: model[a] = d;
         2'b11: ;
         2'b00: begin model = '0; model[a] = d; end
         default: model = '0;
      endcase
      e.q = model; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compares each edge's result shortly after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (q !== e.q) begin
               n_fail++;
               $display("FAIL %s: q=%b expected %b", e.tag, q, e.q);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R5 reset state: clear mode first
      step(1'b1, 3'd5, 1'b1, 1'b0, "R5");
      step(1'b0, 3'd0, 1'b1, 1'b0, "R5");
      // R7 R1 serial load 1,0,1,1,0,0,1,0 into cells 0..7
      step(1'b1, 3'd0, 1'b0, 1'b1, "R1");
      step(1'b0, 3'd1, 1'b0, 1'b1, "R1");
      step(1'b1, 3'd2, 1'b0, 1'b1, "R1");
      step(1'b1, 3'd3, 1'b0, 1'b1, "R1");
      step(1'b0, 3'd4, 1'b0, 1'b1, "R1");
      step(1'b0, 3'd5, 1'b0, 1'b1, "R1");
      step(1'b1, 3'd6, 1'b0, 1'b1, "R1");
      step(1'b0, 3'd7, 1'b0, 1'b1, "R7");
      // R3 hold ignores din and addr
      step(1'b1, 3'd1, 1'b1, 1'b1, "R3");
      step(1'b0, 3'd0, 1'b1, 1'b1, "R3");
      step(1'b1, 3'd7, 1'b1, 1'b1, "R3");
      // R2 overwrite single cells, rest kept
      step(1'b0, 3'd2, 1'b0, 1'b1, "R2");
      step(1'b1, 3'd4, 1'b0, 1'b1, "R2");
      step(1'b1, 3'd4, 1'b0, 1'b1, "R2");
      // fill to all ones
      for (int k = 0; k < NCELL; k++) step(1'b1, AW'(k), 1'b0, 1'b1, "R1");
      // R4 demux from full row: one bit survives
      step(1'b1, 3'd3, 1'b0, 1'b0, "R4");
      // R6 hold keeps the one-hot word
      step(1'b0, 3'd6, 1'b1, 1'b1, "R6");
      step(1'b1, 3'd0, 1'b1, 1'b1, "R6");
      // R4 demux with din 0 gives all zero, then walk the decoder
      step(1'b0, 3'd3, 1'b0, 1'b0, "R4");
      for (int k = 0; k < NCELL; k++) step(1'b1, AW'(k), 1'b0, 1'b0, "R4");
      // R8 write then demux then clear on back-to-back edges
      step(1'b1, 3'd1, 1'b0, 1'b1, "R8");
      step(1'b1, 3'd5, 1'b0, 1'b0, "R8");
      step(1'b1, 3'd5, 1'b1, 1'b0, "R8");
      step(1'b1, 3'd2, 1'b0, 1'b1, "R8");
      // R5 clear from a loaded row
      for (int k = 0; k < NCELL; k++) step(1'b1, AW'(k), 1'b0, 1'b1, "R1");
      step(1'b1, 3'd4, 1'b1, 1'b0, "R5");
      step(1'b0, 3'd4, 1'b1, 1'b1, "R3");
      // drain the scoreboard
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule